// File: doc/BRIEF.md
# RF Front-End Control Bus Write Slave

This block is the write side of a slave on the two-wire RF front-end control bus. The bus has a clock line and a data line. The block samples both lines with the system clock. It finds the start condition and shifts in the command frame. The frame is accepted only when its 4-bit slave address matches the slave identifier stored in the block. Each accepted data byte goes into a local space of 32 registers of 8 bits each.

Three write forms are understood:
- **Compact mask write:** the 7-bit payload travels inside the command frame and lands in register 0x00.
- **Single-register write:** a 5-bit address, followed by one data frame.
- **Burst write:** a byte count and a starting-address frame, followed by up to sixteen data frames. The address steps by one for each data frame.

Every frame carries an odd parity bit. A bad frame ends the sequence. The block never drives the data line.

The system around the block reads the register space in full from a flat image port. Each accepted byte is also announced on a one-cycle write strobe, so that a neighbour can react to single updates.

Top module: `rffe_wr_slave`

## Requirements
- R1: After reset, register 0x00 and every writable data register read 0x00. Register 0x1D reads PRODUCT_ID (default 0x83) and register 0x1E reads MAKER_ID[7:0] (default 0xA5). Register 0x1F reads {2'b00, MAKER_ID[9:8], SLAVE_ID_INIT}, which is 0x17 by default. The `slave_id` port carries bits [3:0] of register 0x1F.
- R2: A start condition is the data line rising and then falling while the clock line stays low. Bits are taken at falling edges of the clock line, MSB first. A new start condition abandons any partly received sequence, so that sequence writes nothing.
- R3: The command frame has 12 bits, {SA[3:0], OP[7:0]}, followed by its parity bit. When OP[7] is 1, OP[6:0] is written to register 0x00 as {1'b0, OP[6:0]}.
- R4: When OP[7:5] is 010, OP[4:0] is a register address. Exactly one 8-bit data frame with parity follows, and its byte is stored at that address.
- R5: When OP[7:4] is 0000, OP[3:0] is a count N. An 8-bit address frame follows, then N+1 data frames. These are written to consecutive addresses, starting at the address in the address frame.
- R6: A burst write stops after the byte that lands on 0x1F. Further data frames in that sequence are discarded.
- R7: Each frame is followed by a parity bit that makes the number of ones in the frame, parity included, odd. A parity error drops that frame and every later frame of the sequence. Bytes accepted earlier in the sequence stay written.
- R8: A command whose SA differs from bits [3:0] of register 0x1F is ignored, together with all of its frames.
- R9: A sequence is ignored in two cases: an opcode outside the three forms (for example OP[7:5]=011, or OP[7:4] from 0001 to 0011), or a burst address frame with any of bits [7:5] set.
- R10: Registers 0x1D and 0x1E cannot be changed. A write to 0x1F changes only bits [3:0]. The new slave identifier applies from the next command onward.
- R11: Register 0x00 holds 7 bits. Its bit 7 always reads 0, including after a single-register write of 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It samples both bus lines. |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Bus clock line, already synchronised to `clk` |
| sdata | input | 1 | Bus data line, already synchronised to `clk` |
| wr_stb | output | 1 | One-cycle pulse for each accepted data byte |
| wr_addr | output | 5 | Register address of the accepted byte |
| wr_data | output | 8 | Accepted byte, in the form in which it was received (the compact form shows {0, mask}) |
| slave_id | output | 4 | Current slave identifier |
| reg_image | output | 256 | All 32 registers. Register k sits at bits [8k+7:8k]. |

## Verification
The stimulus covers:
- each of the three write forms, with ordinary addresses and data;
- a full sixteen-byte burst, and a burst that runs into the top address;
- parity faults placed in the command frame, in a data frame and in the middle of a burst;
- a foreign slave address, reserved opcodes, and an out-of-range burst address;
- a sequence cut short by a fresh start condition.

A scoreboard holds the exact list of byte writes expected from each pattern. It therefore separates several faults that would otherwise look alike: a dropped byte, an extra byte, a byte at the wrong step of the address, and a write after an abort. Comparing the full register image after each pattern shows the masked bits, the read-only identity bytes, and the point at which a changed slave identifier takes over.

// File: rtl/rffe_wr_pkg.sv
`timescale 1ns/1ps
package rffe_wr_pkg;
    localparam int SA_W      = 4;
    localparam int OP_W      = 8;
    localparam int BYTE_W    = 8;
    localparam int CMD_W     = SA_W + OP_W;
    localparam int LEN_W     = 4;
    localparam int REG_COUNT = 32;

    typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_ADDR, ST_DATA} fsm_state_t;
    typedef enum logic [1:0] {OP_MASK0, OP_SINGLE, OP_BURST, OP_NONE} op_kind_t;

    typedef struct packed {
        logic [SA_W-1:0] sa;
        logic [OP_W-1:0] op;
    } cmd_frame_t;

    // true when payload plus parity bit holds an odd count of ones
    function automatic logic odd_ok(input logic [CMD_W:0] bits);
        return ^bits;
    endfunction

    function automatic op_kind_t classify(input logic [OP_W-1:0] op);
        if (op[7])                    return OP_MASK0;
        else if (op[7:5] == 3'b010)   return OP_SINGLE;
        else if (op[7:4] == 4'b0000)  return OP_BURST;
        else                          return OP_NONE;
    endfunction
endpackage

// File: rtl/rffe_line_sampler.sv
`timescale 1ns/1ps
module rffe_line_sampler (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sdata,
    output logic bit_stb,
    output logic bit_val,
    output logic ssc
);
    logic sclk_q, sdata_q, sclk_p, sdata_p, armed;
    logic quiet;

    assign quiet = !sclk_q && !sclk_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sdata_q <= 1'b0;
            sclk_p  <= 1'b0;
            sdata_p <= 1'b0;
            armed   <= 1'b0;
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
            ssc     <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            sdata_q <= sdata;
            sclk_p  <= sclk_q;
            sdata_p <= sdata_q;
            bit_stb <= sclk_p && !sclk_q;
            bit_val <= sdata_q;
            ssc     <= 1'b0;
            if (!quiet)
                armed <= 1'b0;
            else if (!sdata_p && sdata_q)
                armed <= 1'b1;
            else if (armed && sdata_p && !sdata_q) begin
                armed <= 1'b0;
                ssc   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rffe_frame_fsm.sv
`timescale 1ns/1ps
module rffe_frame_fsm
    import rffe_wr_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int LAST_ADR = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ssc,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [SA_W-1:0]   slave_id,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam logic [CNT_W-1:0]  CMD_END  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0]  BYTE_END = CNT_W'(BYTE_W);
    localparam logic [ADDR_W-1:0] TOP      = ADDR_W'(LAST_ADR);

    fsm_state_t        state;
    logic [CMD_W-1:0]  sr;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] cur;
    logic [LEN_W-1:0]  left;

    cmd_frame_t        cf;
    logic [BYTE_W-1:0] byte_in;
    logic              cmd_par_ok, byte_par_ok, frame_end;

    assign cf          = cmd_frame_t'(sr);
    assign byte_in     = sr[BYTE_W-1:0];
    assign cmd_par_ok  = odd_ok({sr, bit_val});
    assign byte_par_ok = odd_ok({{(CMD_W-BYTE_W){1'b0}}, byte_in, bit_val});
    assign frame_end   = (state == ST_CMD) ? (cnt == CMD_END) : (cnt == BYTE_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sr      <= '0;
            cnt     <= '0;
            cur     <= '0;
            left    <= '0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ssc) begin
                state <= ST_CMD;
                cnt   <= '0;
            end else if (bit_stb && state != ST_IDLE) begin
                if (!frame_end) begin
                    sr  <= {sr[CMD_W-2:0], bit_val};
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                    unique case (state)
                        ST_CMD: begin
                            state <= ST_IDLE;
                            if (cmd_par_ok && cf.sa == slave_id) begin
                                unique case (classify(cf.op))
                                    OP_MASK0: begin
                                        wr_stb  <= 1'b1;
                                        wr_addr <= '0;
                                        wr_data <= {1'b0, cf.op[6:0]};
                                    end
                                    OP_SINGLE: begin
                                        cur   <= cf.op[ADDR_W-1:0];
                                        left  <= '0;
                                        state <= ST_DATA;
                                    end
                                    OP_BURST: begin
                                        left  <= cf.op[LEN_W-1:0];
                                        state <= ST_ADDR;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            if (byte_par_ok && (byte_in >> ADDR_W) == '0) begin
                                cur   <= byte_in[ADDR_W-1:0];
                                state <= ST_DATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_DATA: begin
                            if (byte_par_ok) begin
                                wr_stb  <= 1'b1;
                                wr_addr <= cur;
                                wr_data <= byte_in;
                                if (left == '0 || cur == TOP)
                                    state <= ST_IDLE;
                                else begin
                                    left <= left - 1'b1;
                                    cur  <= cur + 1'b1;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/rffe_regfile.sv
`timescale 1ns/1ps
module rffe_regfile
    import rffe_wr_pkg::*;
#(
    parameter int          NREGS         = REG_COUNT,
    parameter logic [7:0]  PRODUCT_ID    = 8'h83,
    parameter logic [9:0]  MAKER_ID      = 10'h1A5,
    parameter logic [3:0]  SLAVE_ID_INIT = 4'h7,
    localparam int         ADDR_W        = $clog2(NREGS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_stb,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [NREGS*BYTE_W-1:0] reg_image,
    output logic [SA_W-1:0]         slave_id
);
    localparam int ID_AT  = NREGS - 1;
    localparam int MID_AT = NREGS - 2;
    localparam int PID_AT = NREGS - 3;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_mask
            logic [6:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else if (wr_stb && wr_addr == ADDR_W'(i)) q <= wr_data[6:0];
            end
            assign reg_image[i*BYTE_W +: BYTE_W] = {1'b0, q};
        end else if (i == PID_AT) begin : g_pid
            assign reg_image[i*BYTE_W +: BYTE_W] = PRODUCT_ID;
        end else if (i == MID_AT) begin : g_mid
            assign reg_image[i*BYTE_W +: BYTE_W] = MAKER_ID[7:0];
        end else if (i == ID_AT) begin : g_sid
            logic [SA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= SLAVE_ID_INIT;
                else if (wr_stb && wr_addr == ADDR_W'(i)) q <= wr_data[SA_W-1:0];
            end
            assign reg_image[i*BYTE_W +: BYTE_W] = {2'b00, MAKER_ID[9:8], q};
        end else begin : g_plain
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else if (wr_stb && wr_addr == ADDR_W'(i)) q <= wr_data;
            end
            assign reg_image[i*BYTE_W +: BYTE_W] = q;
        end
    end

    assign slave_id = reg_image[ID_AT*BYTE_W +: SA_W];
endmodule

// File: rtl/rffe_wr_slave.sv
`timescale 1ns/1ps
module rffe_wr_slave
    import rffe_wr_pkg::*;
#(
    parameter int          NREGS         = REG_COUNT,
    parameter logic [7:0]  PRODUCT_ID    = 8'h83,
    parameter logic [9:0]  MAKER_ID      = 10'h1A5,
    parameter logic [3:0]  SLAVE_ID_INIT = 4'h7,
    localparam int         ADDR_W        = $clog2(NREGS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk,
    input  logic                    sdata,
    output logic                    wr_stb,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [BYTE_W-1:0]       wr_data,
    output logic [SA_W-1:0]         slave_id,
    output logic [NREGS*BYTE_W-1:0] reg_image
);
    logic ssc_pulse, bit_stb, bit_val;

    rffe_line_sampler u_line (
        .clk     (clk),
        .rst     (rst),
        .sclk    (sclk),
        .sdata   (sdata),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .ssc     (ssc_pulse)
    );

    rffe_frame_fsm #(
        .ADDR_W   (ADDR_W),
        .LAST_ADR (NREGS - 1)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ssc      (ssc_pulse),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .slave_id (slave_id),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    rffe_regfile #(
        .NREGS         (NREGS),
        .PRODUCT_ID    (PRODUCT_ID),
        .MAKER_ID      (MAKER_ID),
        .SLAVE_ID_INIT (SLAVE_ID_INIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .reg_image (reg_image),
        .slave_id  (slave_id)
    );
endmodule

// File: rtl/rffe_wr_slave_chk.sv
`timescale 1ns/1ps
module rffe_wr_slave_chk
    import rffe_wr_pkg::*;
#(
    parameter int  NREGS  = REG_COUNT,
    localparam int ADDR_W = $clog2(NREGS)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ssc,
    input logic                    wr_stb,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [BYTE_W-1:0]       wr_data,
    input logic [SA_W-1:0]         slave_id,
    input logic [NREGS*BYTE_W-1:0] reg_image
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(NREGS - 1);

    logic              seen, hit_top, l_stb;
    logic [4:0]        burst_n;
    logic [ADDR_W-1:0] prev, l_addr;
    logic [BYTE_W-1:0] l_data, l_byte;
    logic              l_plain;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0; hit_top <= 1'b0; l_stb <= 1'b0;
            burst_n <= '0; prev <= '0; l_addr <= '0; l_data <= '0;
        end else begin
            l_stb  <= wr_stb;
            l_addr <= wr_addr;
            l_data <= wr_data;
            if (ssc) begin
                seen    <= 1'b1;
                burst_n <= '0;
                hit_top <= 1'b0;
            end else if (wr_stb) begin
                burst_n <= burst_n + 1'b1;
                prev    <= wr_addr;
                if (wr_addr == TOP) hit_top <= 1'b1;
            end
        end
    end

    assign l_byte  = reg_image[{l_addr, 3'b000} +: BYTE_W];
    assign l_plain = (l_addr != '0) && (int'(l_addr) < NREGS - 3);

    assert_start_first_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> seen);
    assert_mask_bit7_R11: assert property (@(posedge clk) disable iff (rst)
        (l_stb && l_addr == '0) |-> (l_byte == {1'b0, l_data[6:0]}));
    assert_store_R4: assert property (@(posedge clk) disable iff (rst)
        (l_stb && l_plain) |-> (l_byte == l_data));
    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ssc && burst_n != '0) |-> (wr_addr == prev + 1'b1));
    assert_burst_len_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ssc) |-> (burst_n < 5'd16));
    assert_stop_at_top_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ssc) |-> !hit_top);
    assert_id_update_R10: assert property (@(posedge clk) disable iff (rst)
        (l_stb && l_addr == TOP) |-> (slave_id == l_data[SA_W-1:0]));
endmodule

bind rffe_wr_slave rffe_wr_slave_chk #(.NREGS(NREGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ssc       (ssc_pulse),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .slave_id  (slave_id),
    .reg_image (reg_image)
);

// File: tb/sim_rffe_wr_slave.sv
`timescale 1ns/1ps
module sim_rffe_wr_slave;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         sdata = 1'b0;
    logic         wr_stb;
    logic [4:0]   wr_addr;
    logic [7:0]   wr_data;
    logic [3:0]   slave_id;
    logic [255:0] reg_image;

    rffe_wr_slave u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .slave_id(slave_id), .reg_image(reg_image)
    );

    always #2.5 clk = ~clk;

    typedef struct { logic [4:0] a; logic [7:0] d; } wr_t;
    wr_t        exp_q[$];
    logic [7:0] model [32];
    int         checks = 0;
    int         fails  = 0;
    string      cur_req = "R1";

    function automatic logic [3:0] m_id();
        return model[31][3:0];
    endfunction

    task automatic push(input logic [4:0] a, input logic [7:0] d);
        wr_t it;
        it.a = a; it.d = d;
        exp_q.push_back(it);
        if (a == 5'd0)       model[0] = {1'b0, d[6:0]};
        else if (a == 5'd31) model[31] = {model[31][7:4], d[3:0]};
        else if (a != 5'd29 && a != 5'd30) model[a] = d;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && wr_stb) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s unexpected write: actual a=%0h d=%0h expected none",
                             cur_req, wr_addr, wr_data);
                end else begin
                    wr_t it;
                    it = exp_q.pop_front();
                    if (it.a !== wr_addr || it.d !== wr_data) begin
                        fails++;
                        $display("FAIL %s write: actual a=%0h d=%0h expected a=%0h d=%0h",
                                 cur_req, wr_addr, wr_data, it.a, it.d);
                    end
                end
            end
        end
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        sclk = 1'b1; sdata = b; half();
        sclk = 1'b0; half();
    endtask

    task automatic start_seq();
        sdata = 1'b0; half();
        sdata = 1'b1; half();
        sdata = 1'b0; half();
    endtask

    task automatic put_frame(input logic [11:0] v, input int n, input logic flip);
        logic p;
        p = 1'b1;
        for (int i = n - 1; i >= 0; i--) begin
            put_bit(v[i]);
            p = p ^ v[i];
        end
        put_bit(p ^ flip);
    endtask

    task automatic settle();
        put_bit(1'b0);
        repeat (12) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s missing writes: actual pending=%0d expected 0", cur_req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic check_image(input string tag);
        int bad;
        bad = -1;
        for (int i = 31; i >= 0; i--)
            if (reg_image[i*8 +: 8] !== model[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s reg %0h: actual %0h expected %0h", tag, bad,
                     reg_image[bad*8 +: 8], model[bad]);
        end
        checks++;
        if (slave_id !== m_id()) begin
            fails++;
            $display("FAIL %s slave_id: actual %0h expected %0h", tag, slave_id, m_id());
        end
    endtask

    task automatic do_mask(input logic [3:0] sa, input logic [6:0] mask, input logic flip);
        if (sa == m_id() && !flip) push(5'd0, {1'b0, mask});
        start_seq();
        put_frame({sa, 1'b1, mask}, 12, flip);
        settle();
    endtask

    task automatic do_single(input logic [3:0] sa, input logic [4:0] a, input logic [7:0] d,
                             input logic fc, input logic fd);
        if (sa == m_id() && !fc && !fd) push(a, d);
        start_seq();
        put_frame({sa, 3'b010, a}, 12, fc);
        put_frame({4'b0, d}, 8, fd);
        settle();
    endtask

    task automatic do_burst(input logic [3:0] sa, input logic [7:0] start, input logic [3:0] cnt,
                            input logic [7:0] base, input int bad_idx);
        if (sa == m_id() && start < 8'd32) begin
            for (int k = 0; k <= int'(cnt); k++) begin
                if (k == bad_idx || int'(start) + k > 31) break;
                push(5'(int'(start) + k), base + 8'(k * 7));
            end
        end
        start_seq();
        put_frame({sa, 4'b0000, cnt}, 12, 1'b0);
        put_frame({4'b0, start}, 8, 1'b0);
        for (int k = 0; k <= int'(cnt); k++)
            put_frame({4'b0, base + 8'(k * 7)}, 8, k == bad_idx);
        settle();
    endtask

    task automatic do_raw(input logic [3:0] sa, input logic [7:0] op, input logic [7:0] d);
        start_seq();
        put_frame({sa, op}, 12, 1'b0);
        put_frame({4'b0, d}, 8, 1'b0);
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        model[29] = 8'h83;
        model[30] = 8'hA5;
        model[31] = 8'h17;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        cur_req = "R1"; check_image("R1");

        cur_req = "R3"; do_mask(4'h7, 7'h55, 1'b0); check_image("R3");

        cur_req = "R4";
        do_single(4'h7, 5'h05, 8'hA5, 1'b0, 1'b0);
        do_single(4'h7, 5'h10, 8'h3C, 1'b0, 1'b0);
        check_image("R4");

        cur_req = "R11"; do_single(4'h7, 5'h00, 8'hFF, 1'b0, 1'b0); check_image("R11");

        cur_req = "R5";
        do_burst(4'h7, 8'h02, 4'd2, 8'h11, -1);
        do_burst(4'h7, 8'h12, 4'd0, 8'h44, -1);
        do_burst(4'h7, 8'h03, 4'd15, 8'h20, -1);
        check_image("R5");

        cur_req = "R6"; do_burst(4'h7, 8'h1B, 4'd7, 8'h5B, -1); check_image("R6");

        cur_req = "R7";
        do_burst(4'h7, 8'h08, 4'd3, 8'h90, 2);
        do_single(4'h7, 5'h06, 8'h66, 1'b1, 1'b0);
        do_single(4'h7, 5'h06, 8'h67, 1'b0, 1'b1);
        do_mask(4'h7, 7'h0F, 1'b1);
        check_image("R7");

        cur_req = "R8";
        do_single(4'h2, 5'h07, 8'hEE, 1'b0, 1'b0);
        do_mask(4'h3, 7'h01, 1'b0);
        check_image("R8");

        cur_req = "R9";
        do_raw(4'h7, 8'b0110_0101, 8'hCC);
        do_raw(4'h7, 8'b0001_0010, 8'hCD);
        do_burst(4'h7, 8'hE4, 4'd1, 8'h70, -1);
        check_image("R9");

        cur_req = "R10";
        do_single(4'h7, 5'h1F, 8'hF3, 1'b0, 1'b0);
        do_single(4'h7, 5'h05, 8'h99, 1'b0, 1'b0);
        do_single(4'h3, 5'h05, 8'h9A, 1'b0, 1'b0);
        do_single(4'h3, 5'h1D, 8'h00, 1'b0, 1'b0);
        do_single(4'h3, 5'h1E, 8'h11, 1'b0, 1'b0);
        check_image("R10");

        cur_req = "R2";
        start_seq();
        for (int i = 0; i < 6; i++) put_bit(i[0]);
        do_single(4'h3, 5'h06, 8'h5A, 1'b0, 1'b0);
        start_seq();
        put_frame({4'h3, 3'b010, 5'h07}, 12, 1'b0);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        do_single(4'h3, 5'h08, 8'hB4, 1'b0, 1'b0);
        check_image("R2");

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule